// File: doc/BRIEF.md
# Triple Clock Lockstep Checker

This block watches three redundant copies of a clock and finds the copy that has stopped or slipped. Each copy runs its own free-running 8-bit counter in its own clock domain. The counters are cleared and released together under control of a reference clock. Each count crosses into the reference domain in Gray code through a two-stage synchroniser. In the reference domain the three counts are compared with a tolerance of one count, so that synchroniser skew does not look like a fault.

When one counter disagrees with the other two, and those two agree with each other, for four reference cycles in a row, that counter's generator is named as failed. A reset pulse of sixteen reference cycles then goes to that generator alone. The three counters are cleared again for eight reference cycles and restarted together, and monitoring resumes. If no two counters agree for four cycles in a row, no single culprit can be named. A global fault flag is then raised and held instead.

The `start` input begins monitoring. It also restarts monitoring from any condition: it clears the fault flag, cancels a pulse in progress, and clears and releases all three counters together.

Top module: `clk_lockstep_checker`

## Requirements
- R1: After reset, `gen_rst` is 0 and `fault_all` is 0. Both stay 0 until `start` is pulsed, even when the monitored clocks disagree.
- R2: With three healthy clocks, counting never leads to action, including across the 255-to-0 wrap of the 8-bit counters.
- R3: Two counts are taken as agreeing when their difference modulo 256 is 0, +1 or -1. A counter that lags by one count causes no action.
- R4: A counter is declared odd once it disagrees with both others, while those two agree, on four consecutive reference cycles. A mismatch that lasts three cycles causes no action.
- R5: A declaration drives `gen_rst[i]` high for exactly 16 reference cycles. Here i is the index of the odd counter: 0, 1 or 2, matching `gen_clk[i]`. No other bit of `gen_rst` is high at the same time.
- R6: After the pulse, all counters are held cleared for 8 reference cycles and then restarted together. A recovered generator then causes no further action.
- R7: No two counters agree on four consecutive cycles: `fault_all` goes high, `gen_rst` stays 0. `fault_all` stays high until `start`.
- R8: `start` takes effect on the next reference cycle from any condition. It clears `fault_all`, ends a reset pulse in progress, and begins an 8-cycle clear followed by a common restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for comparison and control |
| rst | input | 1 | Synchronous active-high reset |
| gen_clk | input | 3 | The three monitored redundant clocks |
| start | input | 1 | One-cycle request to clear and restart the counters (ref domain) |
| gen_rst | output | 3 | Per-generator reset pulse, bit i for `gen_clk[i]` |
| fault_all | output | 1 | All three counters mutually disagree |

## Verification
Some properties are checked on every reference cycle:
- at most one reset line is high;
- a pulse never runs beyond sixteen cycles, and only `start` cuts it short;
- the fault flag excludes any reset and holds until `start`;
- `start` always clears both outputs.

Only the bench's scenarios can show the rest. These are:
- the four-cycle persistence boundary, built from a three-cycle and a four-cycle slip;
- the ±1 tolerance and the wrap at 255;
- that the right generator is named;
- that a recovered clock stays quiet after the common restart.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_PULSE,
        ST_HALT
    } lc_state_e;

    // Which counter the vote singles out
    typedef enum logic [2:0] {
        CAND_NONE,
        CAND_0,
        CAND_1,
        CAND_2,
        CAND_ALL
    } lc_cand_e;

    typedef struct packed {
        logic p01;
        logic p12;
        logic p02;
    } lc_agree_t;

    // Gray helpers on a 32-bit carrier; callers zero-extend and truncate
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/lc_domain_counter.sv
module lc_domain_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] gray_q
);
    import lockstep_pkg::*;

    logic             run_s1, run_s2;
    logic [CNT_W-1:0] bin_q, bin_n;

    always_comb begin
        bin_n = run_s2 ? bin_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_s1 <= 1'b0;
            run_s2 <= 1'b0;
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            run_s1 <= run;
            run_s2 <= run_s1;
            bin_q  <= bin_n;
            gray_q <= CNT_W'(to_gray(32'(bin_n)));
        end
    end
endmodule

// File: rtl/lc_gray_sync.sv
module lc_gray_sync #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);
    import lockstep_pkg::*;

    logic [CNT_W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    always_comb begin
        bin_out = CNT_W'(from_gray(32'(stage2)));
    end
endmodule

// File: rtl/lc_vote.sv
module lc_vote #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0]      cnt [3],
    output lockstep_pkg::lc_cand_e cand
);
    import lockstep_pkg::*;

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] MINUS = '1;

    function automatic logic close(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        logic [CNT_W-1:0] d;
        d = a - b;
        return (d == '0) || (d == ONE) || (d == MINUS);
    endfunction

    lc_agree_t agr;

    always_comb begin
        agr.p01 = close(cnt[0], cnt[1]);
        agr.p12 = close(cnt[1], cnt[2]);
        agr.p02 = close(cnt[0], cnt[2]);
        unique case (agr)
            3'b000:  cand = CAND_ALL;
            3'b100:  cand = CAND_2;
            3'b010:  cand = CAND_0;
            3'b001:  cand = CAND_1;
            default: cand = CAND_NONE;
        endcase
    end
endmodule

// File: rtl/clk_lockstep_checker.sv
module clk_lockstep_checker #(
    parameter int CNT_W     = 8,
    parameter int PERSIST   = 4,
    parameter int PULSE_LEN = 16,
    parameter int CLEAR_LEN = 8
) (
    input  logic       ref_clk,
    input  logic       rst,
    input  logic [2:0] gen_clk,
    input  logic       start,
    output logic [2:0] gen_rst,
    output logic       fault_all
);
    import lockstep_pkg::*;

    localparam int TMR_MAX = (PULSE_LEN > CLEAR_LEN) ? PULSE_LEN : CLEAR_LEN;
    localparam int TMR_W   = $clog2(TMR_MAX);
    localparam int PC_W    = (PERSIST > 2) ? $clog2(PERSIST) : 1;
    localparam logic [TMR_W-1:0] PULSE_END = TMR_W'(PULSE_LEN - 1);
    localparam logic [TMR_W-1:0] CLEAR_END = TMR_W'(CLEAR_LEN - 1);
    localparam logic [PC_W-1:0]  PC_END    = PC_W'(PERSIST - 1);

    lc_state_e        state;
    lc_cand_e         cand, last_cand;
    logic [TMR_W-1:0] tmr;
    logic [PC_W-1:0]  pcnt;
    logic [1:0]       odd_idx;
    logic             run;
    logic [CNT_W-1:0] gray_dom [3];
    logic [CNT_W-1:0] cnt_ref  [3];

    assign run = (state == ST_RUN);

    for (genvar g = 0; g < 3; g++) begin : g_lane
        lc_domain_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (gen_clk[g]),
            .rst    (rst),
            .run    (run),
            .gray_q (gray_dom[g])
        );
        lc_gray_sync #(.CNT_W(CNT_W)) u_sync (
            .clk     (ref_clk),
            .rst     (rst),
            .gray_in (gray_dom[g]),
            .bin_out (cnt_ref[g])
        );
    end

    lc_vote #(.CNT_W(CNT_W)) u_vote (
        .cnt  (cnt_ref),
        .cand (cand)
    );

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            pcnt      <= '0;
            last_cand <= CAND_NONE;
            odd_idx   <= '0;
        end else if (start) begin
            state     <= ST_CLEAR;
            tmr       <= '0;
            pcnt      <= '0;
            last_cand <= CAND_NONE;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    if (tmr == CLEAR_END) begin
                        state <= ST_RUN;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (cand == CAND_NONE) begin
                        pcnt      <= '0;
                        last_cand <= CAND_NONE;
                    end else if (cand != last_cand) begin
                        pcnt      <= PC_W'(1);
                        last_cand <= cand;
                    end else if (pcnt == PC_END) begin
                        pcnt      <= '0;
                        last_cand <= CAND_NONE;
                        tmr       <= '0;
                        if (cand == CAND_ALL) begin
                            state <= ST_HALT;
                        end else begin
                            state   <= ST_PULSE;
                            odd_idx <= (cand == CAND_0) ? 2'd0 :
                                       (cand == CAND_1) ? 2'd1 : 2'd2;
                        end
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tmr == PULSE_END) begin
                        state <= ST_CLEAR;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        gen_rst = '0;
        if (state == ST_PULSE) gen_rst[odd_idx] = 1'b1;
        fault_all = (state == ST_HALT);
    end
endmodule

// File: rtl/clk_lockstep_checker_sva.sv
module clk_lockstep_checker_sva #(
    parameter int PULSE_LEN = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [2:0] gen_rst,
    input logic       fault_all
);
    localparam int LEN_W = $clog2(PULSE_LEN) + 1;

    logic [LEN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else if (|gen_rst) run_len <= run_len + 1'b1;
        else run_len <= '0;
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gen_rst == 3'b000 && !fault_all));

    p_one_line_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gen_rst));

    p_pulse_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (|gen_rst) |-> (run_len < LEN_W'(PULSE_LEN)));

    p_pulse_full_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(|gen_rst) && !$past(start)) |-> ($past(run_len) == LEN_W'(PULSE_LEN - 1)));

    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        fault_all |-> (gen_rst == 3'b000));

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (fault_all && !start) |=> fault_all);

    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!fault_all && gen_rst == 3'b000));
endmodule

bind clk_lockstep_checker clk_lockstep_checker_sva #(.PULSE_LEN(PULSE_LEN)) u_sva (
    .clk       (ref_clk),
    .rst       (rst),
    .start     (start),
    .gen_rst   (gen_rst),
    .fault_all (fault_all)
);

// File: tb/test_clk_lockstep_checker.sv
module test_clk_lockstep_checker;

    logic       ref_clk = 1'b0;
    logic       rst     = 1'b1;
    logic       start   = 1'b0;
    logic [2:0] en      = 3'b111;
    logic [2:0] gen_clk;
    logic [2:0] gen_rst;
    logic       fault_all;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always #10 ref_clk = ~ref_clk;   // 50 MHz

    assign gen_clk[0] = ref_clk & en[0];
    assign gen_clk[1] = ref_clk & en[1];
    assign gen_clk[2] = ref_clk & en[2];

    clk_lockstep_checker i_clk_lockstep_checker (
        .ref_clk   (ref_clk),
        .rst       (rst),
        .gen_clk   (gen_clk),
        .start     (start),
        .gen_rst   (gen_rst),
        .fault_all (fault_all)
    );

    // ---------------- behavioural reference model ----------------
    // phase: 0 waiting, 1 clearing, 2 watching, 3 pulsing, 4 halted
    int phase = 0, ptime = 0, streak = 0, suspect = -1, culprit = 0;
    int dom_q [3][$];          // run level delivered to each domain, two deep
    int count [3] = '{0, 0, 0};
    int ref_q [3][$];          // counts in flight to the reference side
    int exp_rst = 0, exp_fault = 0;

    function automatic bit near(int a, int b);
        int d;
        d = (a - b + 256) % 256;
        return d == 0 || d == 1 || d == 255;
    endfunction

    function automatic int seen(int x);
        return ref_q[x][0];
    endfunction

    initial begin
        for (int x = 0; x < 3; x++) begin
            dom_q[x] = '{0, 0};
            ref_q[x] = '{0, 0};
        end
    end

    always @(posedge ref_clk) begin
        if (rst) begin
            phase = 0; ptime = 0; streak = 0; suspect = -1; culprit = 0;
            for (int x = 0; x < 3; x++) begin
                dom_q[x] = '{0, 0};
                ref_q[x] = '{0, 0};
                count[x] = 0;
            end
        end else begin
            int  who;
            int  lvl;
            bit  a01, a12, a02;
            a01 = near(seen(0), seen(1));
            a12 = near(seen(1), seen(2));
            a02 = near(seen(0), seen(2));
            if (!a01 && !a12 && !a02)     who = 3;
            else if (a01 && !a12 && !a02) who = 2;
            else if (a12 && !a01 && !a02) who = 0;
            else if (a02 && !a01 && !a12) who = 1;
            else                          who = -1;
            lvl = (phase == 2);
            for (int x = 0; x < 3; x++) begin
                void'(ref_q[x].pop_front());
                ref_q[x].push_back(count[x]);
                if (en[x]) begin
                    count[x] = dom_q[x][1] ? (count[x] + 1) % 256 : 0;
                    void'(dom_q[x].pop_back());
                    dom_q[x].push_front(lvl);
                end
            end
            if (start) begin
                phase = 1; ptime = 0; streak = 0; suspect = -1;
            end else if (phase == 1) begin
                if (ptime == 7) begin phase = 2; ptime = 0; end else ptime++;
            end else if (phase == 2) begin
                if (who < 0) begin
                    streak = 0; suspect = -1;
                end else if (who != suspect) begin
                    streak = 1; suspect = who;
                end else if (streak == 3) begin
                    streak = 0; suspect = -1; ptime = 0;
                    if (who == 3) phase = 4;
                    else begin phase = 3; culprit = who; end
                end else streak++;
            end else if (phase == 3) begin
                if (ptime == 15) begin phase = 1; ptime = 0; end else ptime++;
            end
        end
        exp_rst   = (phase == 3) ? (1 << culprit) : 0;
        exp_fault = (phase == 4);
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int pulse_mask = 0, cur_len = 0, last_len = 0;

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge ref_clk);
            if (!rst) begin
                check(int'(gen_rst) == exp_rst, cur_req, "gen_rst", int'(gen_rst), exp_rst);
                check(int'(fault_all) == exp_fault, cur_req, "fault_all", int'(fault_all), exp_fault);
            end
            pulse_mask |= int'(gen_rst);
            if (gen_rst != 3'b000) cur_len++;
            else if (cur_len > 0) begin last_len = cur_len; cur_len = 0; end
            for (int x = 0; x < 3; x++) if (gen_rst[x]) en[x] = 1'b1;  // generator recovers
        end
    endtask

    task automatic restart();
        start = 1'b1; tick(1); start = 1'b0; tick(20);
        pulse_mask = 0; last_len = 0;
    endtask

    task automatic slip(input int gap);
        en[0] = 1'b0; tick(2); en[0] = 1'b1;
        tick(gap);
        en[1] = 1'b0; en[2] = 1'b0; tick(2); en[1] = 1'b1; en[2] = 1'b1;
        tick(40);
    endtask

    initial begin
        // R1: reset state, then no action without start even with a dead clock
        tick(4);
        rst = 1'b0;
        tick(1);
        check(gen_rst == 3'b000 && !fault_all, "R1", "outputs after reset", int'(gen_rst), 0);
        en[0] = 1'b0; tick(20); en[0] = 1'b1; tick(5);
        check(pulse_mask == 0 && !fault_all, "R1", "idle before start", pulse_mask, 0);

        // R2: healthy clocks through the counter wrap
        cur_req = "R2";
        restart();
        tick(300);
        check(pulse_mask == 0 && !fault_all, "R2", "healthy run with wrap", pulse_mask, 0);

        // R3: one-count lag is tolerated, also across the wrap
        cur_req = "R3";
        restart();
        en[1] = 1'b0; tick(1); en[1] = 1'b1;
        tick(300);
        check(pulse_mask == 0 && !fault_all, "R3", "lag of one", pulse_mask, 0);

        // R4: three-cycle slip ignored, four-cycle slip names generator 0
        cur_req = "R4";
        restart();
        slip(2);
        check(pulse_mask == 0, "R4", "three-cycle mismatch", pulse_mask, 0);
        restart();
        slip(3);
        tick(40);
        check(pulse_mask == 1, "R4", "four-cycle mismatch line", pulse_mask, 1);
        cur_req = "R5";
        check(last_len == 16, "R5", "pulse length", last_len, 16);

        // R6: recovered generator is quiet after the common restart
        cur_req = "R6";
        pulse_mask = 0;
        tick(150);
        check(pulse_mask == 0 && !fault_all, "R6", "quiet after recovery", pulse_mask, 0);

        // R4/R5: dead clock 1 is singled out
        cur_req = "R4";
        restart();
        en[1] = 1'b0;
        tick(60);
        check(pulse_mask == 2, "R4", "dead clock 1 line", pulse_mask, 2);
        check(last_len == 16, "R5", "pulse length line 1", last_len, 16);
        cur_req = "R6";
        pulse_mask = 0;
        tick(100);
        check(pulse_mask == 0, "R6", "quiet after clock 1 recovery", pulse_mask, 0);

        // R7: three-way disagreement
        cur_req = "R7";
        restart();
        en[0] = 1'b0; en[1] = 1'b0; tick(2); en[0] = 1'b1; tick(2); en[1] = 1'b1;
        tick(30);
        check(fault_all == 1'b1, "R7", "global fault", int'(fault_all), 1);
        check(pulse_mask == 0, "R7", "no reset on global fault", pulse_mask, 0);
        tick(60);
        check(fault_all == 1'b1, "R7", "fault held", int'(fault_all), 1);

        // R8: start clears the fault, and aborts a pulse
        cur_req = "R8";
        start = 1'b1; tick(1); start = 1'b0; tick(1);
        check(fault_all == 1'b0, "R8", "fault cleared by start", int'(fault_all), 0);
        tick(40);
        en[2] = 1'b0;
        while (gen_rst == 3'b000) tick(1);
        tick(3);
        start = 1'b1; tick(1); start = 1'b0; tick(1);
        check(gen_rst == 3'b000, "R8", "pulse cut by start", int'(gen_rst), 0);
        pulse_mask = 0;
        tick(80);
        check(pulse_mask == 0 && !fault_all, "R8", "quiet after restart", pulse_mask, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule